// File: doc/BRIEF.md
# Two-Word Burst DDR SRAM Model

This block is a synthesizable model of a small synchronous pipelined SRAM with a double-data-rate data interface and a fixed burst of two words. Every access moves exactly two words. The second word's address comes from the base address with its lowest bit flipped, so a burst always stays inside one aligned pair of words. Both phases of the input clock are represented by a single internal clock at twice the K rate, together with a phase flag. The first rising edge after reset release is a K edge. After that, K-bar and K edges alternate.

A command is taken only on a K edge, and only if no burst holds that edge. A write collects its two data words on the next two edges, together with a byte-enable mask for each word. A read presents its pair on the output bus 1.5 K cycles after the command edge, with a valid flag. An echo clock pair runs with the read data so that a receiver can capture it. Writes update the array at the moment they are captured. A read issued right after a write to the same pair therefore returns the new data.

Top module: `ddr_burst_sram`

## Requirements
- R1: While reset is asserted, rdValid is 0, rdData is all zeros and echoClk is 0.
- R2: Commands are sampled only on K edges, which are the even-numbered edges counted from the first edge after reset release. A cmdEn on a K-bar edge has no effect.
- R3: After a command is accepted, the following K edge (two edges later) ignores cmdEn. The next command can be taken four edges after the accepted one.
- R4: A write accepted on edge e stores wrData sampled on edge e+1 as the first word and wrData sampled on edge e+2 as the second word.
- R5: The byte enables are sampled with each write word. A lane is 9 bits when the data width is a multiple of 9 and 8 bits otherwise. Bit i of wrByteEn writes bits [i*lane+lane-1 : i*lane], and lanes whose bit is 0 keep their previous contents.
- R6: A read accepted on edge e shows its first word after edge e+3 and its second word after edge e+4. rdValid is 1 for exactly those two half-cycles.
- R7: The second word of a burst is at the base address with bit 0 inverted, so an odd base returns the odd word first and the even word second.
- R8: A read accepted on the first edge allowed after a write to the same pair returns the newly written data.
- R9: echoClk is 1 in the half-cycle after a K edge and 0 in the half-cycle after a K-bar edge. echoClkN is its complement, and a first read word is always presented with echoClk low.
- R10: rdData is all zeros whenever rdValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate; its rising edges alternate K and K-bar |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdEn | input | 1 | Command request, sampled on K edges |
| cmdWrite | input | 1 | 1 selects a write burst, 0 a read burst |
| addr | input | ADDR_W | Burst base word address |
| wrData | input | DATA_W | Write word, one per edge during a write burst |
| wrByteEn | input | LANES | Active-high lane enables for the current write word |
| rdData | output | DATA_W | Read word, zero while not valid |
| rdValid | output | 1 | High during the two half-cycles that carry read words |
| echoClk | output | 1 | Echo clock, high after K edges |
| echoClkN | output | 1 | Complement of echoClk |

## Verification
Two cases are hard to produce from the ports. One is a request that lands on a blocked edge: a command on a K-bar edge, or on the K edge right after an accepted command. The other is a read that lands on the very first edge allowed after a write to the same pair. Directed sequences line requests up on chosen edges by tracking the edge count from reset, and then read the target address back to show whether it changed. A long stretch then drives requests on every edge, with random addresses, data, masks and enables, against a behavioural model that works on edge numbers.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;
  // Strobes from the burst controller to the datapath, one set per edge
  typedef struct packed {
    logic latch;   // capture a new base address
    logic wrEn;    // write the current data word
    logic wrOdd;   // current write word is the second of the pair
    logic rdLoad;  // load the output register from the array
    logic rdOdd;   // current read word is the second of the pair
  } burstStb_t;
endpackage

// File: rtl/ddr_burst_ctrl.sv
module ddr_burst_ctrl
  import ddr_burst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdEn,
  input  logic      cmdWrite,
  output burstStb_t stb,
  output logic      echoClk
);
  localparam int STAGE_W = 3;
  localparam logic [STAGE_W-1:0] ST_IDLE = 3'd0;
  localparam logic [STAGE_W-1:0] ST_LAST = 3'd4;

  logic               phase;   // 0: this edge is a K edge
  logic [STAGE_W-1:0] stage;   // edges since the accepted command
  logic               isWrite;
  logic               accept;

  assign accept = cmdEn && !phase && (stage == ST_IDLE || stage == ST_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      stage   <= ST_IDLE;
      isWrite <= 1'b0;
      echoClk <= 1'b0;
    end else begin
      phase   <= ~phase;
      echoClk <= ~phase;
      if (accept) begin
        stage   <= 3'd1;
        isWrite <= cmdWrite;
      end else if (stage == ST_LAST) begin
        stage <= ST_IDLE;
      end else if (stage != ST_IDLE) begin
        stage <= stage + 3'd1;
      end
    end
  end

  always_comb begin
    stb.latch  = accept;
    stb.wrEn   = isWrite && (stage == 3'd1 || stage == 3'd2);
    stb.wrOdd  = (stage == 3'd2);
    stb.rdLoad = !isWrite && (stage == 3'd3 || stage == ST_LAST);
    stb.rdOdd  = (stage == ST_LAST);
  end

  // R2: an accepted command is followed by a half-cycle with echo high (a K edge)
  p_accept_on_k_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.latch |=> echoClk);
  // R3: the K edge after an accepted command never accepts
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.latch |=> ##1 !stb.latch);
  // R4: the first write word is always followed by the second
  p_write_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && !stb.wrOdd) |=> (stb.wrEn && stb.wrOdd));
  // R9: the echo clock toggles on every edge
  p_echo_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (echoClk != $past(echoClk)));
endmodule

// File: rtl/ddr_burst_dp.sv
module ddr_burst_dp
  import ddr_burst_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  localparam int LANE_W = (DATA_W % 9 == 0) ? 9 : 8,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStb_t         stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  wrByteEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] wordAddr;
  logic              oddSel;

  // 1-bit burst counter: flips the low address bit for the second word
  assign oddSel   = stb.wrEn ? stb.wrOdd : stb.rdOdd;
  assign wordAddr = {baseAddr[ADDR_W-1:1], baseAddr[0] ^ oddSel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseAddr <= '0;
    else if (stb.latch) baseAddr <= addr;
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrByteEn[l]) mem[wordAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdLoad;
      rdData  <= stb.rdLoad ? mem[wordAddr] : '0;
    end
  end

  // R6: a read pair always lasts two half-cycles
  p_valid_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid);
  p_valid_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |=> !rdValid);
  // R4/R6: write and read strobes never share an edge
  p_no_wr_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> !stb.rdLoad);
  // R10: idle output bus is zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  localparam int LANE_W = (DATA_W % 9 == 0) ? 9 : 8,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  wrByteEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              echoClk,
  output logic              echoClkN
);
  ddr_burst_pkg::burstStb_t stb;

  ddr_burst_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdEn    (cmdEn),
    .cmdWrite (cmdWrite),
    .stb      (stb),
    .echoClk  (echoClk)
  );

  ddr_burst_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addr     (addr),
    .wrData   (wrData),
    .wrByteEn (wrByteEn),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign echoClkN = ~echoClk;

  // R9: the first read word is launched with the echo clock low
  p_first_word_echo_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> !echoClk);
endmodule

// File: tb/ddr_burst_sram_bench.sv
module ddr_burst_sram_bench;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdEn = 1'b0, cmdWrite = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NL-1:0] wrByteEn = '0;
  logic [DW-1:0] rdData;
  logic rdValid, echoClk, echoClkN;

  always #4 clk = ~clk;  // 125 MHz

  ddr_burst_sram #(.DATA_W(DW), .ADDR_W(AW)) u_ddr_burst_sram (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .cmdWrite(cmdWrite), .addr(addr),
    .wrData(wrData), .wrByteEn(wrByteEn), .rdData(rdData), .rdValid(rdValid),
    .echoClk(echoClk), .echoClkN(echoClkN));

  int nChk = 0, nFail = 0;
  string curTag = "R4";
  bit running = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, indexed by edge number since reset release
  logic [DW-1:0] mMem [64];
  int wrSched [int];
  int rdSched [int];
  int n = 0, nextFree = 0;
  logic mValid = 1'b0, mEcho = 1'b0;
  logic [DW-1:0] mData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      n = 0; nextFree = 0; mValid = 1'b0; mData = '0; mEcho = 1'b0;
      wrSched.delete(); rdSched.delete();
    end else begin
      if (wrSched.exists(n)) begin
        for (int l = 0; l < NL; l++)
          if (wrByteEn[l]) mMem[wrSched[n]][l*LW +: LW] = wrData[l*LW +: LW];
        wrSched.delete(n);
      end
      mValid = 1'b0; mData = '0;
      if (rdSched.exists(n)) begin
        mValid = 1'b1; mData = mMem[rdSched[n]];
        rdSched.delete(n);
      end
      mEcho = (n % 2 == 0);
      if (n % 2 == 0 && n >= nextFree && cmdEn) begin
        nextFree = n + 4;
        if (cmdWrite) begin
          wrSched[n+1] = int'(addr); wrSched[n+2] = int'(addr ^ 6'd1);
        end else begin
          rdSched[n+3] = int'(addr); rdSched[n+4] = int'(addr ^ 6'd1);
        end
      end
      n++;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      check(rdValid == mValid, {"R6 ", curTag}, rdValid, mValid);
      check(rdData == mData, {"R10 R7 ", curTag}, rdData, mData);
      check(echoClk == mEcho && echoClkN == !mEcho, "R9 echo", {echoClk, echoClkN}, {mEcho, !mEcho});
    end
  end

  task automatic drive(input logic en, input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [NL-1:0] be);
    cmdEn = en; cmdWrite = wr; addr = a; wrData = d; wrByteEn = be;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic alignK();
    if (n % 2 == 1) idle();
  endtask

  task automatic writeBurst(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [NL-1:0] b0,
                            input logic [DW-1:0] d1, input logic [NL-1:0] b1);
    alignK();
    drive(1'b1, 1'b1, a, '0, '0);
    drive(1'b0, 1'b0, '0, d0, b0);
    drive(1'b0, 1'b0, '0, d1, b1);
    idle();
  endtask

  task automatic readBurst(input logic [AW-1:0] a);
    alignK();
    drive(1'b1, 1'b0, a, '0, '0);
    idle(); idle(); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rdValid == 1'b0, "R1 rdValid", rdValid, 0);
    check(rdData == '0, "R1 rdData", rdData, 0);
    check(echoClk == 1'b0, "R1 echoClk", echoClk, 0);
    rstN = 1'b1;
    running = 1'b1;

    curTag = "R4 fill";
    for (int i = 0; i < 64; i += 2)
      writeBurst(6'(i), 18'(i * 1111 + 7), 2'b11, 18'(i * 2222 + 3), 2'b11);
    for (int i = 0; i < 64; i += 8) readBurst(6'(i));

    curTag = "R5 bytes";
    writeBurst(6'd5, 18'h3FFFF, 2'b01, 18'h2AAAA, 2'b10);
    readBurst(6'd4);

    curTag = "R7 odd base";
    readBurst(6'd7);
    readBurst(6'd10);

    curTag = "R8 write then read";
    writeBurst(6'd12, 18'h12345, 2'b11, 18'h0BEEF, 2'b11);
    readBurst(6'd12);
    writeBurst(6'd33, 18'h01111, 2'b11, 18'h02222, 2'b11);
    readBurst(6'd33);

    curTag = "R2 kbar command";
    alignK();
    idle();  // next edge is K-bar
    drive(1'b1, 1'b1, 6'd20, 18'h15555, 2'b11);
    idle(); idle(); idle();
    readBurst(6'd20);

    curTag = "R3 blocked edge";
    alignK();
    drive(1'b1, 1'b0, 6'd22, '0, '0);
    idle();
    drive(1'b1, 1'b1, 6'd24, 18'h3C3C3, 2'b11);
    idle(); idle(); idle(); idle();
    readBurst(6'd24);

    curTag = "R2 R3 random";
    for (int i = 0; i < 600; i++)
      drive(($urandom % 3) == 0, 1'($urandom % 2), 6'($urandom % 64), 18'($urandom), 2'($urandom % 4));
    repeat (6) idle();

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule